// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one accepted read or write command into the column addresses of its burst, one address per clock. The burst length and ordering come from a programmed mode word: a three-bit length code, an ordering bit that picks a linear walk or an XOR-scrambled walk, and a bit that forces every write to a single beat while reads keep the programmed length. A 256-column full-page burst is available only with linear ordering. An unsupported mode is flagged, and the burst falls back to one beat.

The block also times the per-beat data mask. During a write beat the mask applies in the same cycle it is presented. During a read beat it turns into an output-disable two clocks later. A stop request ends the running burst after the current beat, and a new start always begins a fresh burst in the next cycle, even if another burst is still running. The controller around the block supplies the commands and the mode fields. It consumes the addresses, the beat strobes and the mask timing.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The length code maps 000, 001, 010 and 011 to bursts of 1, 2, 4 and 8 beats. Beats occupy consecutive cycles, starting in the cycle after the start is sampled, with `beat_valid` high. `beat_last` is high only on the final beat of the natural length.
- R2: With `mode_ilv`=0 (linear), the low log2(length) column bits count up by one and wrap inside the aligned block, while the upper bits keep their start value. Example: a 4-beat burst from 0x2D gives 0x2D, 0x2E, 0x2F, 0x2C.
- R3: With `mode_ilv`=1 (scrambled), the low log2(length) bits of beat i equal the start column's low bits XOR i, and the upper bits are held. Example: an 8-beat burst from 0x2D gives 0x2D, 0x2C, 0x2F, 0x2E, 0x29, 0x28, 0x2B, 0x2A.
- R4: Code 111 with linear ordering gives a 256-beat burst. The column counts up modulo 256 from the start column, and `beat_last` is set on beat 256.
- R5: Codes 100, 101 and 110, and code 111 with scrambled ordering, are errors. The burst is then one beat long, with `len_err` and `beat_last` high on that beat.
- R6: With `mode_wr_single`=1, a write burst has one beat and `beat_last` is set on it, while a read burst uses the programmed length.
- R7: If `stop` is high in a beat cycle, that beat is the last one driven, and `beat_valid` is low in the next cycle. This holds at any length, including full page. A stop with no burst running has no effect: no beat appears.
- R8: A start sampled during a running burst, even in the same cycle as a stop, ends the old burst. The new burst's first beat, at the new column and bank, appears in the next cycle.
- R9: `wr_mask_out` equals `mask_in` in the same cycle during a write beat, and is 0 on read beats and when idle.
- R10: `rd_hiz_out` is high exactly in the cycle two clocks after a cycle in which `mask_in` was high during a read beat.
- R11: After reset, `beat_valid`, `beat_last`, `len_err`, `wr_mask_out` and `rd_hiz_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the command fields below |
| start_is_write | input | 1 | 1 = write burst, 0 = read burst |
| start_col | input | 8 | Start column |
| start_bank | input | 2 | Bank of the burst |
| stop | input | 1 | End the running burst after the current beat |
| mode_len | input | 3 | Programmed burst length code |
| mode_ilv | input | 1 | 0 = linear ordering, 1 = scrambled ordering |
| mode_wr_single | input | 1 | Force writes to one beat |
| mask_in | input | 1 | Per-beat data mask |
| col_out | output | 8 | Column of the current beat |
| bank_out | output | 2 | Bank of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Final beat of the natural burst length |
| beat_is_write | output | 1 | Current beat belongs to a write |
| len_err | output | 1 | Current burst used an unsupported mode |
| wr_mask_out | output | 1 | Write data mask, zero latency |
| rd_hiz_out | output | 1 | Read output disable, two-cycle latency |

## Verification
A stop and a fresh start can land in the same cycle, and the start must win. This is provoked by raising both in the third beat of a linear 8-beat read while a scrambled 4-beat write is commanded. The scoreboard expects exactly three beats of the old burst followed at once by the new burst's columns. Two mask latencies also overlap: a read burst's delayed output-disable can still be pending when a write beat's same-cycle mask is active. The monitor therefore keeps a two-deep history of masked read beats and judges `rd_hiz_out` against it in every cycle, independently of `wr_mask_out`.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  // length codes that select a supported burst
  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

endpackage

// File: rtl/sbc_mode_decode.sv
module sbc_mode_decode #(
  parameter int COL_W = 8,
  parameter int LOG_W = $clog2(COL_W + 1)
) (
  input  logic [2:0]       len_code,
  input  logic             order_xor,
  input  logic             wr_single,
  input  logic             is_write,
  output logic [LOG_W-1:0] span_log2,
  output logic             code_err
);
  import sbc_pkg::*;

  always_comb begin
    code_err  = 1'b0;
    span_log2 = '0;
    case (len_code)
      LEN_ONE:   span_log2 = LOG_W'(0);
      LEN_TWO:   span_log2 = LOG_W'(1);
      LEN_FOUR:  span_log2 = LOG_W'(2);
      LEN_EIGHT: span_log2 = LOG_W'(3);
      LEN_PAGE: begin
        if (order_e'(order_xor) == ORD_XOR) code_err = 1'b1;
        else                                span_log2 = LOG_W'(COL_W);
      end
      default:   code_err = 1'b1;
    endcase
    if (is_write && wr_single) span_log2 = '0;
  end

endmodule

// File: rtl/sbc_mask_delay.sv
module sbc_mask_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/sbc_col_seq.sv
module sbc_col_seq #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int LOG_W  = $clog2(COL_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COL_W-1:0]  load_col,
  input  logic [BANK_W-1:0] load_bank,
  input  logic              load_wr,
  input  logic              load_xor,
  input  logic              load_err,
  input  logic [LOG_W-1:0]  load_log2,
  input  logic              stop,
  output logic              active,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic              is_wr,
  output logic              err,
  output logic              last,
  output logic              end_evt
);

  // bits below the burst span
  function automatic logic [COL_W-1:0] low_mask(input logic [LOG_W-1:0] l2);
    low_mask = '0;
    for (int i = 0; i < COL_W; i++) low_mask[i] = (i < int'(l2));
  endfunction

  // linear walk: count inside the aligned block
  function automatic logic [COL_W-1:0] linear_step(input logic [COL_W-1:0] cur,
                                                   input logic [COL_W-1:0] m);
    linear_step = (cur & ~m) | ((cur + COL_W'(1)) & m);
  endfunction

  // scrambled walk: start bits XOR beat index
  function automatic logic [COL_W-1:0] xor_pick(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] idx,
                                                input logic [COL_W-1:0] m);
    xor_pick = (base & ~m) | ((base ^ idx) & m);
  endfunction

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  logic [LOG_W-1:0] log2_q;
  logic             xor_q;
  logic [COL_W-1:0] span_m;
  logic [COL_W-1:0] cnt_nx;
  logic [COL_W-1:0] col_nx;

  assign span_m  = low_mask(log2_q);
  assign cnt_nx  = cnt_q + COL_W'(1);
  assign col_nx  = xor_q ? xor_pick(base_q, cnt_nx, span_m) : linear_step(col, span_m);
  assign last    = active && (cnt_q == span_m);
  assign end_evt = active && (last || stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      bank   <= '0;
      is_wr  <= 1'b0;
      xor_q  <= 1'b0;
      err    <= 1'b0;
      log2_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      col    <= load_col;
      base_q <= load_col;
      cnt_q  <= '0;
      bank   <= load_bank;
      is_wr  <= load_wr;
      xor_q  <= load_xor;
      err    <= load_err;
      log2_q <= load_log2;
    end else if (end_evt) begin
      active <= 1'b0;
      err    <= 1'b0;
    end else if (active) begin
      cnt_q <= cnt_nx;
      col   <= col_nx;
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W       = 8,
  parameter int BANK_W      = 2,
  parameter int RD_MASK_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_is_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  input  logic              stop,
  input  logic [2:0]        mode_len,
  input  logic              mode_ilv,
  input  logic              mode_wr_single,
  input  logic              mask_in,
  output logic [COL_W-1:0]  col_out,
  output logic [BANK_W-1:0] bank_out,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              beat_is_write,
  output logic              len_err,
  output logic              wr_mask_out,
  output logic              rd_hiz_out
);
  localparam int LOG_W = $clog2(COL_W + 1);

  logic [LOG_W-1:0] dec_log2;
  logic             dec_err;
  logic             seq_err;
  logic             burst_end;
  logic             rd_mask_src;

  sbc_mode_decode #(.COL_W(COL_W), .LOG_W(LOG_W)) u_dec (
    .len_code  (mode_len),
    .order_xor (mode_ilv),
    .wr_single (mode_wr_single),
    .is_write  (start_is_write),
    .span_log2 (dec_log2),
    .code_err  (dec_err)
  );

  sbc_col_seq #(.COL_W(COL_W), .BANK_W(BANK_W), .LOG_W(LOG_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_col  (start_col),
    .load_bank (start_bank),
    .load_wr   (start_is_write),
    .load_xor  (mode_ilv),
    .load_err  (dec_err),
    .load_log2 (dec_log2),
    .stop      (stop),
    .active    (beat_valid),
    .col       (col_out),
    .bank      (bank_out),
    .is_wr     (beat_is_write),
    .err       (seq_err),
    .last      (beat_last),
    .end_evt   (burst_end)
  );

  assign len_err     = beat_valid & seq_err;
  assign wr_mask_out = beat_valid & beat_is_write & mask_in;
  assign rd_mask_src = beat_valid & ~beat_is_write & mask_in;

  sbc_mask_delay #(.DEPTH(RD_MASK_LAT)) u_rdmask (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rd_mask_src),
    .q     (rd_hiz_out)
  );

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int COL_W       = 8,
  parameter int BANK_W      = 2,
  parameter int RD_MASK_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic [BANK_W-1:0] start_bank,
  input logic              stop,
  input logic              mask_in,
  input logic [COL_W-1:0]  col_out,
  input logic [BANK_W-1:0] bank_out,
  input logic              beat_valid,
  input logic              beat_last,
  input logic              beat_is_write,
  input logic              len_err,
  input logic              wr_mask_out,
  input logic              rd_hiz_out,
  input logic              burst_end
);

  AST_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && (beat_last || stop) && !start) |=> !beat_valid); // R7

  AST_END_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !start) |=> !beat_valid); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col_out == $past(start_col) && bank_out == $past(start_bank))); // R8

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !stop && !start) |=> (beat_valid && $stable(bank_out))); // R2

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && len_err) |-> beat_last); // R5

  AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_out |-> (beat_valid && beat_is_write && mask_in)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (!beat_last && !len_err && !wr_mask_out)); // R11

  generate
    if (RD_MASK_LAT == 2) begin : g_rd
      AST_RD_HIZ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hiz_out |-> $past(mask_in, 2)); // R10
    end
  endgenerate

endmodule

bind sdram_burst_colgen sbc_checker #(
  .COL_W(COL_W), .BANK_W(BANK_W), .RD_MASK_LAT(RD_MASK_LAT)
) u_sbc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .start_col     (start_col),
  .start_bank    (start_bank),
  .stop          (stop),
  .mask_in       (mask_in),
  .col_out       (col_out),
  .bank_out      (bank_out),
  .beat_valid    (beat_valid),
  .beat_last     (beat_last),
  .beat_is_write (beat_is_write),
  .len_err       (len_err),
  .wr_mask_out   (wr_mask_out),
  .rd_hiz_out    (rd_hiz_out),
  .burst_end     (burst_end)
);

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       start_is_write = 1'b0;
  logic [7:0] start_col = '0;
  logic [1:0] start_bank = '0;
  logic       stop = 1'b0;
  logic [2:0] mode_len = '0;
  logic       mode_ilv = 1'b0;
  logic       mode_wr_single = 1'b0;
  logic       mask_in = 1'b0;
  logic [7:0] col_out;
  logic [1:0] bank_out;
  logic       beat_valid, beat_last, beat_is_write, len_err, wr_mask_out, rd_hiz_out;

  always #10 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_is_write(start_is_write),
    .start_col(start_col), .start_bank(start_bank), .stop(stop),
    .mode_len(mode_len), .mode_ilv(mode_ilv), .mode_wr_single(mode_wr_single),
    .mask_in(mask_in), .col_out(col_out), .bank_out(bank_out),
    .beat_valid(beat_valid), .beat_last(beat_last), .beat_is_write(beat_is_write),
    .len_err(len_err), .wr_mask_out(wr_mask_out), .rd_hiz_out(rd_hiz_out)
  );

  typedef struct {
    logic [7:0] col;
    logic [1:0] bank;
    logic       last;
    logic       wr;
    logic       err;
    string      req;
  } beat_t;

  beat_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  logic  mask_en = 1'b0;
  logic  h0 = 1'b0, h1 = 1'b0;
  logic  done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected sequence, computed per beat from the start column
  function automatic void push_burst(input logic [2:0] code, input logic ilv,
                                     input logic wrs, input logic wr,
                                     input logic [7:0] col, input logic [1:0] bank,
                                     input int keep, input string req);
    int   l2, n, m;
    logic err;
    beat_t b;
    err = 1'b0;
    case (code)
      3'd0: l2 = 0;
      3'd1: l2 = 1;
      3'd2: l2 = 2;
      3'd3: l2 = 3;
      3'd7: if (ilv) begin err = 1'b1; l2 = 0; end else l2 = 8;
      default: begin err = 1'b1; l2 = 0; end
    endcase
    if (wr && wrs) l2 = 0;
    n = 1 << l2;
    m = n - 1;
    for (int i = 0; i < n && i < keep; i++) begin
      int c;
      if (ilv) c = (int'(col) & ~m) | ((int'(col) ^ i) & m);
      else     c = (int'(col) & ~m) | ((int'(col) + i) & m);
      b.col  = 8'(c & 255);
      b.bank = bank;
      b.last = (i == n - 1);
      b.wr   = wr;
      b.err  = err;
      b.req  = req;
      exp_q.push_back(b);
    end
  endfunction

  task automatic set_cmd(input logic [2:0] code, input logic ilv, input logic wrs,
                         input logic wr, input logic [7:0] col, input logic [1:0] bank);
    mode_len = code; mode_ilv = ilv; mode_wr_single = wrs;
    start_is_write = wr; start_col = col; start_bank = bank; start = 1'b1;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(posedge clk);
    if (exp_q.size() != 0) begin
      check(0, req, "beats missing", exp_q.size(), 0);
      exp_q.delete();
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  // driver: one burst, optionally stopped at beat stop_at
  task automatic run_burst(input logic [2:0] code, input logic ilv, input logic wrs,
                           input logic wr, input logic [7:0] col, input logic [1:0] bank,
                           input int stop_at, input string req);
    push_burst(code, ilv, wrs, wr, col, bank, (stop_at < 0) ? 1000 : stop_at + 1, req);
    @(posedge clk); #1;
    set_cmd(code, ilv, wrs, wr, col, bank);
    @(posedge clk); #1;
    start = 1'b0;
    if (stop_at >= 0) begin
      repeat (stop_at) @(posedge clk);
      #1 stop = 1'b1;
      @(posedge clk); #1 stop = 1'b0;
    end
    drain(req);
  endtask

  // mask stimulus
  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mask_in = mask_en & lf[0];
    end
  end

  // monitor: pops expected beats and judges both mask paths
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        logic cur_rd;
        beat_t b;
        cur_rd = 1'b0;
        check(rd_hiz_out == h1, "R10", "rd_hiz_out", rd_hiz_out, h1);
        if (beat_valid) begin
          if (exp_q.size() == 0) begin
            check(0, "R7", "unexpected beat at col", col_out, 0);
          end else begin
            b = exp_q.pop_front();
            check({col_out, bank_out, beat_last, beat_is_write, len_err} ==
                  {b.col, b.bank, b.last, b.wr, b.err}, b.req, "beat col/bank/last/wr/err",
                  {col_out, bank_out, beat_last, beat_is_write, len_err},
                  {b.col, b.bank, b.last, b.wr, b.err});
            check(wr_mask_out == (b.wr & mask_in), "R9", "wr_mask_out",
                  wr_mask_out, b.wr & mask_in);
            cur_rd = !b.wr && mask_in;
          end
        end else begin
          check(wr_mask_out == 1'b0, "R9", "idle wr_mask_out", wr_mask_out, 0);
        end
        h1 = h0;
        h0 = cur_rd;
      end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    check(0, "R1", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check({beat_valid, beat_last, len_err, wr_mask_out, rd_hiz_out} == 5'b0, "R11",
          "reset outputs", {beat_valid, beat_last, len_err, wr_mask_out, rd_hiz_out}, 0);

    // R1: each supported length
    run_burst(3'b000, 0, 0, 0, 8'h10, 2'd1, -1, "R1");
    run_burst(3'b001, 0, 0, 0, 8'h11, 2'd2, -1, "R1");
    run_burst(3'b010, 0, 0, 1, 8'h12, 2'd3, -1, "R1");
    run_burst(3'b011, 0, 0, 0, 8'h13, 2'd0, -1, "R1");
    // R2: linear wrap inside aligned block
    run_burst(3'b010, 0, 0, 0, 8'h2D, 2'd1, -1, "R2");
    run_burst(3'b011, 0, 0, 1, 8'hF6, 2'd2, -1, "R2");
    // R3: scrambled ordering
    run_burst(3'b011, 1, 0, 0, 8'h2D, 2'd0, -1, "R3");
    run_burst(3'b001, 1, 0, 1, 8'h41, 2'd3, -1, "R3");
    run_burst(3'b010, 1, 0, 0, 8'h86, 2'd1, -1, "R3");
    // R4: full page wraps through 255
    run_burst(3'b111, 0, 0, 0, 8'hFE, 2'd2, -1, "R4");
    // R5: unsupported modes
    run_burst(3'b100, 0, 0, 0, 8'h20, 2'd0, -1, "R5");
    run_burst(3'b101, 1, 0, 1, 8'h21, 2'd1, -1, "R5");
    run_burst(3'b110, 0, 0, 0, 8'h22, 2'd2, -1, "R5");
    run_burst(3'b111, 1, 0, 0, 8'h23, 2'd3, -1, "R5");
    // R6: single-beat writes, reads keep length
    run_burst(3'b011, 0, 1, 1, 8'h37, 2'd1, -1, "R6");
    run_burst(3'b011, 0, 1, 0, 8'h37, 2'd1, -1, "R6");
    // R7: stop at several points, full page included
    run_burst(3'b111, 0, 0, 0, 8'h80, 2'd0, 5, "R7");
    run_burst(3'b011, 1, 0, 1, 8'h5A, 2'd2, 0, "R7");
    run_burst(3'b010, 0, 0, 0, 8'h03, 2'd3, 3, "R7");
    // R7: stop while idle produces no beat
    @(posedge clk); #1 stop = 1'b1;
    repeat (3) @(posedge clk);
    #1 stop = 1'b0;
    @(negedge clk);
    check(beat_valid == 1'b0, "R7", "idle stop beat_valid", beat_valid, 0);
    // R8: start and stop in the same cycle mid-burst
    push_burst(3'b011, 0, 0, 0, 8'h30, 2'd1, 3, "R8");
    @(posedge clk); #1;
    set_cmd(3'b011, 0, 0, 0, 8'h30, 2'd1);
    @(posedge clk); #1 start = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    push_burst(3'b010, 1, 0, 1, 8'h55, 2'd2, 1000, "R8");
    set_cmd(3'b010, 1, 0, 1, 8'h55, 2'd2);
    stop = 1'b1;
    @(posedge clk); #1 start = 1'b0; stop = 1'b0;
    drain("R8");
    // R9 and R10: masks on write and read bursts, back to back
    mask_en = 1'b1;
    run_burst(3'b011, 0, 0, 1, 8'h60, 2'd0, -1, "R9");
    run_burst(3'b011, 1, 0, 0, 8'h68, 2'd1, -1, "R10");
    push_burst(3'b011, 0, 0, 0, 8'h70, 2'd2, 1000, "R10");
    @(posedge clk); #1 set_cmd(3'b011, 0, 0, 0, 8'h70, 2'd2);
    @(posedge clk); #1 start = 1'b0;
    repeat (7) @(posedge clk);
    #1;
    push_burst(3'b010, 0, 0, 1, 8'h74, 2'd3, 1000, "R9");
    set_cmd(3'b010, 0, 0, 1, 8'h74, 2'd3);
    @(posedge clk); #1 start = 1'b0;
    drain("R9");
    mask_en = 1'b0;
    repeat (4) @(posedge clk);
    done = 1'b1;
    report();
  end

endmodule